// File: doc/BRIEF.md
# CEC Transmit Frame Buffer Controller

This block holds one outgoing CEC frame of up to sixteen bytes and sends it byte by byte to a line encoder. Software, through an internal byte-wide register port, loads the frame bytes and a length value, then issues a two-bit command code. The command can launch the frame, abort it, or restart the buffered frame from its first byte. The controller offers each byte to the encoder over a valid/ready handshake. It then waits for that byte's acknowledge or error result before it offers the next byte.

A two-bit status code shows whether the controller is idle, busy, finished cleanly or finished with an error. A transmit interrupt bit is set on every completion. The bit stays set until software clears it, and it is gated by an active-high enable mask. A buffer-clear control zeroes the stored frame for as long as it is held at 1.

Byte stream rules: the encoder may hold `tx_ready_i` low for any number of cycles. While it does, the offered byte and its last flag do not change, unless the frame is cancelled (signalled by `tx_abort_o`). The result inputs have no back-pressure. A result is taken only while the controller is waiting for one, and a result that arrives at any other time is ignored.

Top module: `cec_tx_frame_ctrl`

## Requirements
- R1: After reset the status reads 0 (idle), the interrupt status word reads 0, `irq_o` is 0, `tx_valid_o` is 0 and every buffer byte reads 0.
- R2: Register port map. Addresses 0x00–0x0F hold frame bytes 0–15 (0x00 is the header, 0x01 the opcode). 0x10 holds the byte count minus one, in 4 bits. 0x11 holds the command, in bits 1:0. 0x13 holds the clear control, in bit 0. 0x93 reads the status code. Read data appears on `reg_rdata_o` one cycle after `reg_rd_i`, and an unmapped address reads 0.
- R3: Writing command code 1 starts a frame only when all three hold: the command register held 0 before the write, the status is not 1, and clear is not held. Status reads 1 from the next cycle. A code-1 write with no code-0 write after the last command is ignored.
- R4: Bytes are offered in address order, from 0 up to the length value. `tx_last_o` is 1 only with the final byte. While `tx_ready_i` is low, the byte is held.
- R5: Only one byte is outstanding at a time. After a byte is accepted, `tx_valid_o` stays low until that byte's result returns.
- R6: If every byte returns with `res_ack_i`=1 and `res_err_i`=0, status becomes 2. The first result with no acknowledge or with an error ends the frame at once with status 3, and no later byte is offered.
- R7: Writing code 2 while status is 1 returns status to 0, pulses `tx_abort_o` for one cycle and sets no interrupt. Code 2 written at any other time has no effect.
- R8: Writing code 3 restarts the buffered frame from byte 0, with status 1, whatever the previous command was. If a frame was in progress, `tx_abort_o` pulses.
- R9: While clear bit 0 is 1, the frame bytes and the length read 0, writes to them are ignored, start commands are ignored, and a frame in progress is cancelled (status 0, `tx_abort_o` pulse).
- R10: Interrupt status bit 1 is set on the cycle the status becomes 2 or 3. It stays set until a cycle with `irq_clear_i[1]`=1 and no new completion; if a clear and a completion fall in the same cycle, the bit stays set. Bits 0 and 2 read 0.
- R11: `irq_o` equals `irq_mask_i[1]` AND interrupt status bit 1.
- R12: While status is 1, writes to the frame bytes and the length are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, one cycle after the read strobe |
| tx_valid_o | output | 1 | Byte offered to the encoder |
| tx_ready_i | input | 1 | Encoder accepts the byte |
| tx_byte_o | output | 8 | Offered byte |
| tx_last_o | output | 1 | Offered byte is the final byte of the frame |
| tx_abort_o | output | 1 | One-cycle pulse: the frame in progress is cancelled |
| res_valid_i | input | 1 | Result for the outstanding byte |
| res_ack_i | input | 1 | The byte was acknowledged |
| res_err_i | input | 1 | The encoder reported an error |
| status_o | output | 2 | 0 idle, 1 busy, 2 sent, 3 sent with error |
| irq_mask_i | input | 3 | Interrupt enable mask, active high |
| irq_clear_i | input | 3 | Interrupt clear, a write-1 pulse per bit |
| irq_status_o | output | 3 | Sticky interrupt status word |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The assertions check several rules on every cycle:
- the offered byte stays still under back-pressure, unless the frame is cancelled;
- `tx_valid_o` drops after each accepted byte;
- a byte is offered only while busy, and `tx_last_o` never appears without `tx_valid_o`;
- an abort pulse never coincides with a finished status;
- the interrupt bit is sticky, and it is set on every move into status 2 or 3.

Some behaviour shows only in the bench's scenarios:
- the byte order and count for random lengths and failure points;
- the need for a no-operation command before a restart;
- restart and abort on a stalled frame, and the clear control blocking writes and starts;
- the clear-versus-completion collision.

// File: rtl/cec_txb_pkg.sv
package cec_txb_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_SEND  = 2'd1,
    CMD_ABORT = 2'd2,
    CMD_NEXT  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    STAT_IDLE = 2'd0,
    STAT_BUSY = 2'd1,
    STAT_SENT = 2'd2,
    STAT_FAIL = 2'd3
  } stat_e;

  typedef enum logic [2:0] {
    F_IDLE,
    F_OFFER,
    F_WAIT,
    F_DONE,
    F_ERR
  } fsm_e;

  localparam int          REG_AW   = 8;
  localparam logic [7:0]  ADR_LEN  = 8'h10;
  localparam logic [7:0]  ADR_CMD  = 8'h11;
  localparam logic [7:0]  ADR_CLR  = 8'h13;
  localparam logic [7:0]  ADR_STAT = 8'h93;

endpackage

// File: rtl/cec_txb_regbank.sv
module cec_txb_regbank
  import cec_txb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic [1:0]        status_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] byte_o,
  output logic [IDX_W-1:0]  len_o,
  output logic              clr_o,
  output logic              cmd_wr_o,
  output logic [1:0]        cmd_code_o,
  output logic [1:0]        cmd_prev_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  len_q;
  logic [1:0]        cmd_q;
  logic              clr_q;
  logic              in_buf;
  logic              frame_wr;
  logic [DATA_W-1:0] rd_mux;

  assign in_buf   = addr_i < REG_AW'(DEPTH);
  assign frame_wr = wr_i && !busy_i && !clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      len_q <= '0;
    end else if (clr_q) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      len_q <= '0;
    end else if (frame_wr) begin
      if (in_buf) mem_q[addr_i[IDX_W-1:0]] <= wdata_i;
      if (addr_i == ADR_LEN) len_q <= wdata_i[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_NOP;
      clr_q <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == ADR_CMD) cmd_q <= wdata_i[1:0];
      if (addr_i == ADR_CLR) clr_q <= wdata_i[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_buf)                 rd_mux = mem_q[addr_i[IDX_W-1:0]];
    else if (addr_i == ADR_LEN)  rd_mux = {{(DATA_W-IDX_W){1'b0}}, len_q};
    else if (addr_i == ADR_CMD)  rd_mux = {{(DATA_W-2){1'b0}}, cmd_q};
    else if (addr_i == ADR_CLR)  rd_mux = {{(DATA_W-1){1'b0}}, clr_q};
    else if (addr_i == ADR_STAT) rd_mux = {{(DATA_W-2){1'b0}}, status_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  assign byte_o     = mem_q[idx_i];
  assign len_o      = len_q;
  assign clr_o      = clr_q;
  assign cmd_wr_o   = wr_i && (addr_i == ADR_CMD);
  assign cmd_code_o = wdata_i[1:0];
  assign cmd_prev_o = cmd_q;

endmodule

// File: rtl/cec_txb_seq.sv
module cec_txb_seq
  import cec_txb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr_i,
  input  logic [1:0]       cmd_code_i,
  input  logic [1:0]       cmd_prev_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] len_i,
  input  logic             tx_ready_i,
  input  logic             res_valid_i,
  input  logic             res_ack_i,
  input  logic             res_err_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             tx_valid_o,
  output logic             tx_last_o,
  output logic             tx_abort_o,
  output logic [1:0]       status_o,
  output logic             busy_o,
  output logic             finish_o
);

  fsm_e             state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             abort_d;
  logic             busy;

  assign busy = (state_q == F_OFFER) || (state_q == F_WAIT);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    abort_d = 1'b0;
    if (clr_i && busy) begin
      state_d = F_IDLE;
      abort_d = 1'b1;
    end else if (cmd_wr_i && cmd_code_i == CMD_NEXT && !clr_i) begin
      state_d = F_OFFER;
      idx_d   = '0;
      abort_d = busy;
    end else if (cmd_wr_i && cmd_code_i == CMD_ABORT && busy) begin
      state_d = F_IDLE;
      abort_d = 1'b1;
    end else if (cmd_wr_i && cmd_code_i == CMD_SEND && cmd_prev_i == CMD_NOP
                 && !busy && !clr_i) begin
      state_d = F_OFFER;
      idx_d   = '0;
    end else begin
      case (state_q)
        F_OFFER: if (tx_ready_i) state_d = F_WAIT;
        F_WAIT: begin
          if (res_valid_i) begin
            if (res_ack_i && !res_err_i) begin
              if (idx_q == len_i) state_d = F_DONE;
              else begin
                state_d = F_OFFER;
                idx_d   = idx_q + 1'b1;
              end
            end else begin
              state_d = F_ERR;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= F_IDLE;
      idx_q      <= '0;
      tx_abort_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      idx_q      <= idx_d;
      tx_abort_o <= abort_d;
    end
  end

  always_comb begin
    case (state_q)
      F_OFFER, F_WAIT: status_o = STAT_BUSY;
      F_DONE:          status_o = STAT_SENT;
      F_ERR:           status_o = STAT_FAIL;
      default:         status_o = STAT_IDLE;
    endcase
  end

  assign idx_o      = idx_q;
  assign tx_valid_o = (state_q == F_OFFER);
  assign tx_last_o  = (state_q == F_OFFER) && (idx_q == len_i);
  assign busy_o     = busy;
  assign finish_o   = busy && ((state_d == F_DONE) || (state_d == F_ERR));

endmodule

// File: rtl/cec_txb_irq.sv
module cec_txb_irq #(
  parameter int INT_W  = 3,
  parameter int TX_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic [INT_W-1:0] mask_i,
  input  logic [INT_W-1:0] clear_i,
  output logic [INT_W-1:0] stat_o,
  output logic             irq_o
);

  logic tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_q <= 1'b0;
    else if (set_i) tx_q <= 1'b1;
    else if (clear_i[TX_BIT]) tx_q <= 1'b0;
  end

  for (genvar g = 0; g < INT_W; g++) begin : g_bit
    if (g == TX_BIT) begin : g_tx
      assign stat_o[g] = tx_q;
    end else begin : g_none
      assign stat_o[g] = 1'b0;
    end
  end

  assign irq_o = |(stat_o & mask_i);

endmodule

// File: rtl/cec_tx_frame_ctrl.sv
module cec_tx_frame_ctrl
  import cec_txb_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int DATA_W     = 8,
  parameter int INT_W      = 3,
  parameter int TX_INT_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              tx_last_o,
  output logic              tx_abort_o,
  input  logic              res_valid_i,
  input  logic              res_ack_i,
  input  logic              res_err_i,
  output logic [1:0]        status_o,
  input  logic [INT_W-1:0]  irq_mask_i,
  input  logic [INT_W-1:0]  irq_clear_i,
  output logic [INT_W-1:0]  irq_status_o,
  output logic              irq_o
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] len;
  logic             clr;
  logic             cmd_wr;
  logic [1:0]       cmd_code;
  logic [1:0]       cmd_prev;
  logic             busy;
  logic             finish;

  cec_txb_regbank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .busy_i     (busy),
    .status_i   (status_o),
    .idx_i      (idx),
    .byte_o     (tx_byte_o),
    .len_o      (len),
    .clr_o      (clr),
    .cmd_wr_o   (cmd_wr),
    .cmd_code_o (cmd_code),
    .cmd_prev_o (cmd_prev)
  );

  cec_txb_seq #(.DEPTH(DEPTH)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr_i    (cmd_wr),
    .cmd_code_i  (cmd_code),
    .cmd_prev_i  (cmd_prev),
    .clr_i       (clr),
    .len_i       (len),
    .tx_ready_i  (tx_ready_i),
    .res_valid_i (res_valid_i),
    .res_ack_i   (res_ack_i),
    .res_err_i   (res_err_i),
    .idx_o       (idx),
    .tx_valid_o  (tx_valid_o),
    .tx_last_o   (tx_last_o),
    .tx_abort_o  (tx_abort_o),
    .status_o    (status_o),
    .busy_o      (busy),
    .finish_o    (finish)
  );

  cec_txb_irq #(.INT_W(INT_W), .TX_BIT(TX_INT_BIT)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (finish),
    .mask_i  (irq_mask_i),
    .clear_i (irq_clear_i),
    .stat_o  (irq_status_o),
    .irq_o   (irq_o)
  );

endmodule

// File: rtl/cec_txb_checker.sv
module cec_txb_checker #(
  parameter int DATA_W = 8,
  parameter int INT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [DATA_W-1:0] tx_byte_o,
  input logic              tx_last_o,
  input logic              tx_abort_o,
  input logic [1:0]        status_o,
  input logic [INT_W-1:0]  irq_clear_i,
  input logic [INT_W-1:0]  irq_status_o
);

  // R4: a stalled byte stays put unless the frame is cancelled
  a_r4_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> tx_abort_o ||
      (tx_valid_o && $stable(tx_byte_o) && $stable(tx_last_o)));

  // R4: last flag only with an offered byte
  a_r4_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last_o |-> tx_valid_o);

  // R5: an accepted byte is not followed by another offer
  a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && tx_ready_i |=> !tx_valid_o || tx_abort_o);

  // R5: bytes are offered only while busy
  a_r5_offer_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> status_o == 2'd1);

  // R7: a cancel pulse never shows a finished status
  a_r7_abort_unfinished: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort_o |-> !status_o[1]);

  // R10: completion sets the interrupt bit
  a_r10_set_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[1] |=> (status_o[1] |-> irq_status_o[1]));

  // R10: the interrupt bit is sticky without a clear
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status_o[1] && !irq_clear_i[1] |=> irq_status_o[1]);

endmodule

bind cec_tx_frame_ctrl cec_txb_checker #(.DATA_W(DATA_W), .INT_W(INT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_valid_o   (tx_valid_o),
  .tx_ready_i   (tx_ready_i),
  .tx_byte_o    (tx_byte_o),
  .tx_last_o    (tx_last_o),
  .tx_abort_o   (tx_abort_o),
  .status_o     (status_o),
  .irq_clear_i  (irq_clear_i),
  .irq_status_o (irq_status_o)
);

// File: tb/cec_tx_frame_ctrl_tb.sv
module cec_tx_frame_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [7:0] reg_addr_i = '0, reg_wdata_i = '0, reg_rdata_o;
  logic       tx_valid_o, tx_ready_i, tx_last_o, tx_abort_o;
  logic [7:0] tx_byte_o;
  logic       res_valid_i, res_ack_i, res_err_i;
  logic [1:0] status_o;
  logic [2:0] irq_mask_i = '0, irq_clear_i = '0, irq_status_o;
  logic       irq_o;

  // encoder model signals and manual overrides
  bit   manual = 0, hold_ready = 0;
  logic e_ready = 0, e_rv = 0, e_ack = 0, e_err = 0;
  logic m_ready = 0, m_rv = 0, m_ack = 0, m_err = 0;
  assign tx_ready_i  = manual ? m_ready : e_ready;
  assign res_valid_i = manual ? m_rv    : e_rv;
  assign res_ack_i   = manual ? m_ack   : e_ack;
  assign res_err_i   = manual ? m_err   : e_err;

  int   plan_nack = -1, plan_err = -1;
  logic [7:0] cap [16];
  bit   cap_last [16];
  int   cap_n = 0;
  bit   pend = 0;
  int   dly = 0;

  int   errors = 0, checks = 0;
  logic [7:0] exp_buf [16];

  always #2 clk = ~clk;

  cec_tx_frame_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_byte_o(tx_byte_o),
    .tx_last_o(tx_last_o), .tx_abort_o(tx_abort_o),
    .res_valid_i(res_valid_i), .res_ack_i(res_ack_i), .res_err_i(res_err_i),
    .status_o(status_o), .irq_mask_i(irq_mask_i), .irq_clear_i(irq_clear_i),
    .irq_status_o(irq_status_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd_i = 1'b1; reg_addr_i = a;
    @(negedge clk);
    reg_rd_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic irq_clear();
    @(negedge clk);
    irq_clear_i = 3'b010;
    @(negedge clk);
    irq_clear_i = 3'b000;
  endtask

  function automatic int first_fail(input int len, input int nk, input int er);
    int f = -1;
    if (nk >= 0 && nk < len) f = nk;
    if (er >= 0 && er < len && (f < 0 || er < f)) f = er;
    return f;
  endfunction

  function automatic int exp_count(input int len, input int nk, input int er);
    int f = first_fail(len, nk, er);
    return (f >= 0) ? f + 1 : len;
  endfunction

  function automatic logic [1:0] exp_stat(input int len, input int nk, input int er);
    return (first_fail(len, nk, er) >= 0) ? 2'd3 : 2'd2;
  endfunction

  // encoder model: random stalls and result latency
  initial begin
    forever begin
      @(negedge clk);
      e_ready = 1'b0;
      e_rv    = 1'b0;
      if (!manual) begin
        if (tx_abort_o) begin
          pend = 0; cap_n = 0;
        end else if (pend) begin
          if (dly == 0) begin
            e_rv  = 1'b1;
            e_ack = (cap_n - 1 != plan_nack);
            e_err = (cap_n - 1 == plan_err);
            pend  = 0;
          end else dly--;
        end else if (tx_valid_o && !hold_ready && ($urandom % 4 != 0) && cap_n < 16) begin
          e_ready = 1'b1;
          cap[cap_n] = tx_byte_o;
          cap_last[cap_n] = tx_last_o;
          cap_n++;
          pend = 1;
          dly = $urandom % 3;
        end
      end
    end
  end

  task automatic wait_not_busy();
    for (int i = 0; i < 3000 && status_o == 2'd1; i++) @(negedge clk);
  endtask

  task automatic load_frame(input int len);
    for (int i = 0; i < len; i++) begin
      exp_buf[i] = 8'($urandom);
      wr(8'(i), exp_buf[i]);
    end
    wr(8'h10, 8'(len - 1));
  endtask

  task automatic run_frame(input int len, input int nk, input int er);
    logic [7:0] d;
    bit ok;
    int n;
    plan_nack = nk; plan_err = er;
    irq_mask_i = 3'($urandom);
    load_frame(len);
    rd(8'h10, d);
    chk("R2 length readback", d, 8'(len - 1));
    rd(8'($urandom % len), d);
    wr(8'h11, 8'h00);
    cap_n = 0;
    wr(8'h11, 8'h01);
    chk("R3 busy after start", status_o, 2'd1);
    wait_not_busy();
    n = exp_count(len, nk, er);
    chk("R6 status", status_o, exp_stat(len, nk, er));
    chk("R6 bytes sent", cap_n, n);
    ok = 1;
    for (int i = 0; i < n && i < cap_n; i++) begin
      if (cap[i] !== exp_buf[i]) ok = 0;
      if (cap_last[i] !== (i == len - 1)) ok = 0;
    end
    chk("R4 byte order and last flag", ok, 1);
    chk("R10 irq set", irq_status_o, 3'b010);
    chk("R11 irq masked", irq_o, irq_mask_i[1]);
    rd(8'h93, d);
    chk("R2 status readback", d, 8'(exp_stat(len, nk, er)));
    irq_clear();
    chk("R10 irq cleared", irq_status_o, 3'b000);
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status_o, 2'd0);
    chk("R1 irq status", irq_status_o, 3'd0);
    chk("R1 irq", irq_o, 1'b0);
    chk("R1 valid", tx_valid_o, 1'b0);
    rd(8'h05, d);
    chk("R1 buffer", d, 8'h00);
    rd(8'h50, d);
    chk("R2 unmapped read", d, 8'h00);

    // directed frames
    run_frame(1, -1, -1);
    run_frame(16, -1, -1);
    run_frame(4, 0, -1);
    run_frame(5, -1, 4);
    run_frame(6, 3, 2);

    // R3: start without a preceding no-operation is ignored
    wr(8'h11, 8'h01);
    chk("R3 start without NOP ignored", status_o, 2'd3);

    // random frames
    for (int k = 0; k < 25; k++) begin
      int len = 1 + ($urandom % 16);
      int nk = ($urandom % 3 == 0) ? int'($urandom % len) : -1;
      int er = ($urandom % 5 == 0) ? int'($urandom % len) : -1;
      run_frame(len, nk, er);
    end

    // R12 and R7: stalled frame
    hold_ready = 1;
    load_frame(3);
    wr(8'h11, 8'h00);
    wr(8'h11, 8'h01);
    wr(8'h00, 8'h77);
    wr(8'h10, 8'h0F);
    rd(8'h00, d);
    chk("R12 byte write ignored while busy", d, exp_buf[0]);
    rd(8'h10, d);
    chk("R12 length write ignored while busy", d, 8'h02);
    wr(8'h11, 8'h02);
    chk("R7 abort status", status_o, 2'd0);
    chk("R7 abort pulse", tx_abort_o, 1'b1);
    @(negedge clk);
    chk("R7 abort pulse one cycle", tx_abort_o, 1'b0);
    chk("R7 no irq", irq_status_o, 3'd0);
    wr(8'h11, 8'h02);
    chk("R7 abort when idle no effect", {status_o, tx_abort_o}, 3'b000);

    // R8 restart from byte 0
    wr(8'h11, 8'h00);
    wr(8'h11, 8'h01);
    wr(8'h11, 8'h03);
    chk("R8 restart pulse", tx_abort_o, 1'b1);
    chk("R8 restart busy", status_o, 2'd1);
    plan_nack = -1; plan_err = -1;
    @(negedge clk);
    cap_n = 0;
    hold_ready = 0;
    wait_not_busy();
    chk("R8 restart completes", status_o, 2'd2);
    chk("R8 restart count", cap_n, 3);
    chk("R8 restart first byte", cap[0], exp_buf[0]);
    irq_clear();

    // R8 restart from finished state without NOP
    cap_n = 0;
    wr(8'h11, 8'h03);
    chk("R8 restart from done busy", status_o, 2'd1);
    wait_not_busy();
    chk("R8 restart from done sent", status_o, 2'd2);
    irq_clear();

    // R9 clear control
    wr(8'h13, 8'h01);
    rd(8'h00, d);
    chk("R9 buffer cleared", d, 8'h00);
    rd(8'h10, d);
    chk("R9 length cleared", d, 8'h00);
    wr(8'h01, 8'h55);
    rd(8'h01, d);
    chk("R9 write ignored while clear", d, 8'h00);
    wr(8'h11, 8'h00);
    wr(8'h11, 8'h01);
    chk("R9 start ignored while clear", status_o, 2'd2);
    wr(8'h13, 8'h00);
    hold_ready = 1;
    load_frame(2);
    wr(8'h11, 8'h00);
    wr(8'h11, 8'h01);
    wr(8'h13, 8'h01);
    @(negedge clk);
    chk("R9 clear cancels frame", status_o, 2'd0);
    chk("R9 clear abort pulse", tx_abort_o, 1'b1);
    wr(8'h13, 8'h00);
    hold_ready = 0;

    // R5 and R10 collision, driven manually
    @(negedge clk);
    manual = 1;
    wr(8'h00, 8'hA5);
    wr(8'h01, 8'h3C);
    wr(8'h10, 8'h01);
    wr(8'h11, 8'h00);
    wr(8'h11, 8'h01);
    chk("R4 first byte", {tx_valid_o, tx_byte_o, tx_last_o}, {1'b1, 8'hA5, 1'b0});
    m_ready = 1;
    @(negedge clk);
    m_ready = 0;
    chk("R5 no offer while waiting", tx_valid_o, 1'b0);
    m_rv = 1; m_ack = 1; m_err = 0;
    @(negedge clk);
    m_rv = 0;
    chk("R4 final byte", {tx_valid_o, tx_byte_o, tx_last_o}, {1'b1, 8'h3C, 1'b1});
    m_ready = 1;
    @(negedge clk);
    m_ready = 0;
    m_rv = 1; irq_clear_i = 3'b010;
    @(negedge clk);
    m_rv = 0; irq_clear_i = 3'b000;
    chk("R6 manual sent", status_o, 2'd2);
    chk("R10 set wins over clear", irq_status_o, 3'b010);
    irq_mask_i = 3'b101;
    @(negedge clk);
    chk("R11 masked off", irq_o, 1'b0);
    irq_mask_i = 3'b010;
    @(negedge clk);
    chk("R11 masked on", irq_o, 1'b1);
    irq_clear();
    chk("R10 cleared after collision", irq_status_o, 3'd0);
    manual = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule